// File: doc/BRIEF.md
# Serial Control Word Loader

This block takes configuration for a dual frequency synthesizer over a three-wire serial link: a serial clock, a data line and a latch enable. All three inputs are already synchronous to the system clock `clk_i`. The block detects rising edges of the serial clock. On each one it shifts the data bit into a 23-bit shift register, first bit at the top. Edges that arrive while the latch enable is high are ignored.

A rising edge of the latch enable commits the shifted word. The two bits shifted in last form a destination code. That code picks one of four holding registers: the intermediate-frequency (IF) reference divider, the IF programmable counter, the radio-frequency (RF) reference divider or the RF programmable counter. The word's fields are copied into the chosen register. Every other register keeps its value.

Some words carry a divide value below the legal minimum of 3. Such a word is rejected: the target keeps its old contents and a sticky error flag is raised.

The block also drives the shared status pin. The pin shows either the lock-detect signal or the phase-comparator monitor signal, as set by a select bit carried in the reference words.

Top module: `cfg_word_loader`

## Requirements
- R1: After reset, both reference divides and both B counts read 3. Both A counts, both prescaler selects, both pump-current selects, the output-pin select and the error flag read 0.
- R2: When the serial clock rises while the latch enable is low, the data bit enters bit 0 of the shift register and every other bit moves up one place. Only the 23 most recent bits are kept. Earlier bits fall off the top.
- R3: A rising edge of the latch enable copies the word into the register picked by word bits [1:0]: 00 IF reference, 01 RF reference, 10 IF programmable, 11 RF programmable. The outputs change in the clock cycle after the edge. No other register changes.
- R4: In a reference word, bits [15:2] are the 14-bit divide value R and bit 16 is the high pump-current select. Bit 17 is the output-pin select.
- R5: In a programmable word, bit 2 is the prescaler select and bits [9:3] are the 7-bit A count. Bits [20:10] are the 11-bit B count. A=0 and B=3 are accepted.
- R6: A reference word with R below 3 is rejected. The reference register and the output-pin select keep their old values, and the error flag goes to 1.
- R7: A programmable word with B below 3 is rejected. The programmable register keeps its old value, and the error flag goes to 1.
- R8: The error flag stays set until the next accepted word, which clears it.
- R9: Serial clock edges while the latch enable is high do not shift. This also holds when the serial clock and the latch enable rise in the same cycle: the load then uses the word as it stood before that edge.
- R10: The status pin equals the monitor input when the output-pin select is 1, and the lock-detect input when it is 0. It follows those inputs without delay.
- R11: The output-pin select is a single shared bit. Any accepted reference word, IF or RF, rewrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, synchronous to clk_i |
| sdata_i | input | 1 | Serial data |
| le_i | input | 1 | Latch enable |
| lock_det_i | input | 1 | Lock-detect signal |
| pd_mon_i | input | 1 | Phase-comparator monitor signal |
| if_ref_div_o | output | 14 | IF reference divide value |
| if_cp_hi_o | output | 1 | IF high pump-current select |
| if_a_o | output | 7 | IF A count |
| if_b_o | output | 11 | IF B count |
| if_psel_o | output | 1 | IF prescaler select |
| rf_ref_div_o | output | 14 | RF reference divide value |
| rf_cp_hi_o | output | 1 | RF high pump-current select |
| rf_a_o | output | 7 | RF A count |
| rf_b_o | output | 11 | RF B count |
| rf_psel_o | output | 1 | RF prescaler select |
| lds_o | output | 1 | Output-pin select |
| err_o | output | 1 | Sticky rejected-word flag |
| ld_pin_o | output | 1 | Shared status pin |

## Verification
A serial clock rise and a latch enable rise can land in the same system-clock cycle. In that case the shift must be dropped and the load must use the word that was already held. The bench forces this by raising both inputs in one drive while the data line carries a 1. It then keeps pulsing the serial clock with the latch enable held high.

A behavioural model, built on a bit queue, is compared with every output on every cycle. The directed checks also confirm that the loaded divide value matches the word sent before the collision, and that a word shifted in afterwards still loads cleanly. Rejected words and the sticky error flag are covered in the same way, one cycle after each latch enable edge.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int SR_W    = 23;
  localparam int CTL_W   = 2;
  localparam int R_W     = 14;
  localparam int A_W     = 7;
  localparam int B_W     = 11;
  localparam int N_CH    = 2;   // 0: IF, 1: RF
  localparam int R_LSB   = CTL_W;
  localparam int CP_BIT  = R_LSB + R_W;
  localparam int LDS_BIT = CP_BIT + 1;
  localparam int PS_BIT  = CTL_W;
  localparam int A_LSB   = PS_BIT + 1;
  localparam int B_LSB   = A_LSB + A_W;

  typedef enum logic [CTL_W-1:0] {
    DST_IF_REF  = 2'b00,
    DST_RF_REF  = 2'b01,
    DST_IF_PROG = 2'b10,
    DST_RF_PROG = 2'b11
  } dst_e;

  typedef struct packed {
    logic [R_W-1:0] r;
    logic           cp_hi;
    logic           lds;
  } ref_t;

  typedef struct packed {
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
    logic           psel;
  } prog_t;
endpackage

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg
  import cfg_loader_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclk_i,
  input  logic            sdata_i,
  input  logic            le_i,
  output logic [SR_W-1:0] word_o,
  output logic            le_rise_o
);
  logic [SR_W-1:0] sr_q;
  logic            sclk_q, le_q;
  logic            shift_en;

  assign shift_en  = sclk_i & ~sclk_q & ~le_i;
  assign le_rise_o = le_i & ~le_q;
  assign word_o    = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      le_q   <= le_i;
      if (shift_en) sr_q <= {sr_q[SR_W-2:0], sdata_i};
    end
  end

  AST_SHIFT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> $stable(sr_q)); // R9
  AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i && !sclk_q && !le_i) |=> (sr_q[SR_W-1:1] == $past(sr_q[SR_W-2:0]))); // R2
endmodule

// File: rtl/cfg_word_decode.sv
module cfg_word_decode
  import cfg_loader_pkg::*;
#(
  parameter int R_MIN = 3,
  parameter int B_MIN = 3
) (
  input  logic [SR_W-1:0] word_i,
  input  logic            le_rise_i,
  output logic [N_CH-1:0] ref_ld_o,
  output logic [N_CH-1:0] prog_ld_o,
  output ref_t            ref_o,
  output prog_t           prog_o,
  output logic            accept_o,
  output logic            reject_o
);
  dst_e dst;
  logic is_prog, ch, ok;

  always_comb begin
    dst        = dst_e'(word_i[CTL_W-1:0]);
    is_prog    = (dst == DST_IF_PROG) || (dst == DST_RF_PROG);
    ch         = (dst == DST_RF_REF) || (dst == DST_RF_PROG);
    ref_o.r     = word_i[R_LSB +: R_W];
    ref_o.cp_hi = word_i[CP_BIT];
    ref_o.lds   = word_i[LDS_BIT];
    prog_o.psel = word_i[PS_BIT];
    prog_o.a    = word_i[A_LSB +: A_W];
    prog_o.b    = word_i[B_LSB +: B_W];
    ok = is_prog ? (int'(prog_o.b) >= B_MIN) : (int'(ref_o.r) >= R_MIN);
    accept_o  = le_rise_i & ok;
    reject_o  = le_rise_i & ~ok;
    ref_ld_o  = '0;
    prog_ld_o = '0;
    if (accept_o) begin
      if (is_prog) prog_ld_o[ch] = 1'b1;
      else         ref_ld_o[ch]  = 1'b1;
    end
  end
endmodule

// File: rtl/cfg_channel_latch.sv
module cfg_channel_latch
  import cfg_loader_pkg::*;
#(
  parameter int R_MIN = 3,
  parameter int B_MIN = 3,
  parameter logic [R_W-1:0] R_RST = R_W'(3),
  parameter logic [B_W-1:0] B_RST = B_W'(3)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ref_ld_i,
  input  logic  prog_ld_i,
  input  ref_t  ref_i,
  input  prog_t prog_i,
  output ref_t  ref_q_o,
  output prog_t prog_q_o
);
  ref_t  ref_q;
  prog_t prog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '{r: R_RST, cp_hi: 1'b0, lds: 1'b0};
      prog_q <= '{a: '0, b: B_RST, psel: 1'b0};
    end else begin
      if (ref_ld_i)  ref_q  <= ref_i;
      if (prog_ld_i) prog_q <= prog_i;
    end
  end

  assign ref_q_o  = ref_q;
  assign prog_q_o = prog_q;

  AST_REF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_ld_i |=> $stable(ref_q)); // R3
  AST_PROG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_ld_i |=> $stable(prog_q)); // R3
  AST_R_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ld_i |-> (int'(ref_i.r) >= R_MIN)); // R6
  AST_B_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_ld_i |-> (int'(prog_i.b) >= B_MIN)); // R7
endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader
  import cfg_loader_pkg::*;
#(
  parameter int R_MIN = 3,
  parameter int B_MIN = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sclk_i,
  input  logic           sdata_i,
  input  logic           le_i,
  input  logic           lock_det_i,
  input  logic           pd_mon_i,
  output logic [R_W-1:0] if_ref_div_o,
  output logic           if_cp_hi_o,
  output logic [A_W-1:0] if_a_o,
  output logic [B_W-1:0] if_b_o,
  output logic           if_psel_o,
  output logic [R_W-1:0] rf_ref_div_o,
  output logic           rf_cp_hi_o,
  output logic [A_W-1:0] rf_a_o,
  output logic [B_W-1:0] rf_b_o,
  output logic           rf_psel_o,
  output logic           lds_o,
  output logic           err_o
  , output logic         ld_pin_o
);
  logic [SR_W-1:0] word;
  logic            le_rise;
  logic [N_CH-1:0] ref_ld, prog_ld;
  ref_t            ref_w;
  prog_t           prog_w;
  logic            accept, reject;
  ref_t            ref_q  [N_CH];
  prog_t           prog_q [N_CH];
  logic            lds_q, err_q;

  cfg_shift_reg u_sr (
    .clk_i, .rst_ni, .sclk_i, .sdata_i, .le_i,
    .word_o(word), .le_rise_o(le_rise)
  );

  cfg_word_decode #(.R_MIN(R_MIN), .B_MIN(B_MIN)) u_dec (
    .word_i(word), .le_rise_i(le_rise),
    .ref_ld_o(ref_ld), .prog_ld_o(prog_ld),
    .ref_o(ref_w), .prog_o(prog_w),
    .accept_o(accept), .reject_o(reject)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    cfg_channel_latch #(
      .R_MIN(R_MIN), .B_MIN(B_MIN),
      .R_RST(R_W'(R_MIN)), .B_RST(B_W'(B_MIN))
    ) u_latch (
      .clk_i, .rst_ni,
      .ref_ld_i(ref_ld[c]), .prog_ld_i(prog_ld[c]),
      .ref_i(ref_w), .prog_i(prog_w),
      .ref_q_o(ref_q[c]), .prog_q_o(prog_q[c])
    );
  end

  // shared pin select follows whichever reference word was accepted last
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lds_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (|ref_ld) lds_q <= ref_w.lds;
      if (reject)      err_q <= 1'b1;
      else if (accept) err_q <= 1'b0;
    end
  end

  assign if_ref_div_o = ref_q[0].r;
  assign if_cp_hi_o   = ref_q[0].cp_hi;
  assign if_a_o       = prog_q[0].a;
  assign if_b_o       = prog_q[0].b;
  assign if_psel_o    = prog_q[0].psel;
  assign rf_ref_div_o = ref_q[1].r;
  assign rf_cp_hi_o   = ref_q[1].cp_hi;
  assign rf_a_o       = prog_q[1].a;
  assign rf_b_o       = prog_q[1].b;
  assign rf_psel_o    = prog_q[1].psel;
  assign lds_o        = lds_q;
  assign err_o        = err_q;
  assign ld_pin_o     = lds_q ? pd_mon_i : lock_det_i;

  AST_ONE_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ref_ld, prog_ld})); // R3
  AST_ERR_ON_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |=> err_o); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !err_o); // R8
  AST_LDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|ref_ld) |=> $stable(lds_o)); // R11
endmodule

// File: tb/cfg_word_loader_test.sv
module cfg_word_loader_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, le = 1'b0, lock_det = 1'b0, pd_mon = 1'b0;
  logic [13:0] if_ref, rf_ref;
  logic [6:0]  if_a, rf_a;
  logic [10:0] if_b, rf_b;
  logic if_cp, rf_cp, if_ps, rf_ps, lds, err, ld_pin;

  cfg_word_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .le_i(le),
    .lock_det_i(lock_det), .pd_mon_i(pd_mon),
    .if_ref_div_o(if_ref), .if_cp_hi_o(if_cp), .if_a_o(if_a), .if_b_o(if_b), .if_psel_o(if_ps),
    .rf_ref_div_o(rf_ref), .rf_cp_hi_o(rf_cp), .rf_a_o(rf_a), .rf_b_o(rf_b), .rf_psel_o(rf_ps),
    .lds_o(lds), .err_o(err), .ld_pin_o(ld_pin)
  );

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // behavioural reference model
  bit q[$];
  int m_ref[2], m_cp[2], m_a[2], m_b[2], m_ps[2];
  int m_lds, m_err;
  bit m_sclk_d, m_le_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q = {};
      for (int i = 0; i < 23; i++) q.push_back(1'b0);
      for (int c = 0; c < 2; c++) begin
        m_ref[c] = 3; m_cp[c] = 0; m_a[c] = 0; m_b[c] = 3; m_ps[c] = 0;
      end
      m_lds = 0; m_err = 0; m_sclk_d = 0; m_le_d = 0;
    end else begin
      if (le && !m_le_d) begin
        logic [22:0] w;
        int dst, ch;
        for (int i = 0; i < 23; i++) w[22-i] = q[i];
        dst = int'(w[1:0]);
        ch = dst % 2;
        if (dst < 2) begin
          if (int'(w[15:2]) < 3) m_err = 1;
          else begin
            m_ref[ch] = int'(w[15:2]); m_cp[ch] = int'(w[16]);
            m_lds = int'(w[17]); m_err = 0;
          end
        end else begin
          if (int'(w[20:10]) < 3) m_err = 1;
          else begin
            m_b[ch] = int'(w[20:10]); m_a[ch] = int'(w[9:3]);
            m_ps[ch] = int'(w[2]); m_err = 0;
          end
        end
      end
      if (sclk && !m_sclk_d && !le) begin
        q.push_back(sdata);
        void'(q.pop_front());
      end
      m_sclk_d = sclk; m_le_d = le;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R4", "model if_ref", int'(if_ref), m_ref[0]);
    chk("R4", "model rf_ref", int'(rf_ref), m_ref[1]);
    chk("R4", "model if_cp", int'(if_cp), m_cp[0]);
    chk("R4", "model rf_cp", int'(rf_cp), m_cp[1]);
    chk("R5", "model if_a", int'(if_a), m_a[0]);
    chk("R5", "model rf_a", int'(rf_a), m_a[1]);
    chk("R5", "model if_b", int'(if_b), m_b[0]);
    chk("R5", "model rf_b", int'(rf_b), m_b[1]);
    chk("R5", "model if_ps", int'(if_ps), m_ps[0]);
    chk("R5", "model rf_ps", int'(rf_ps), m_ps[1]);
    chk("R11", "model lds", int'(lds), m_lds);
    chk("R8", "model err", int'(err), m_err);
    chk("R10", "model ld_pin", int'(ld_pin), m_lds != 0 ? int'(pd_mon) : int'(lock_det));
  end

  function automatic logic [22:0] ref_word(int r, bit cp, bit ls, bit [1:0] ctl);
    return {5'b0, ls, cp, 14'(r), ctl};
  endfunction
  function automatic logic [22:0] prog_word(int a, int b, bit ps, bit [1:0] ctl);
    return {2'b0, 11'(b), 7'(a), ps, ctl};
  endfunction

  task automatic shift_bit(bit b);
    @(posedge clk); #1 sdata = b; sclk = 1'b0;
    @(posedge clk); #1 sclk = 1'b1;
  endtask
  task automatic send(logic [22:0] w);
    for (int i = 22; i >= 0; i--) shift_bit(w[i]);
  endtask
  task automatic latch();
    @(posedge clk); #1 sclk = 1'b0; le = 1'b1;
    @(posedge clk); #1 le = 1'b1;
    @(posedge clk); #1 le = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "if_ref", int'(if_ref), 3);
    chk("R1", "rf_b", int'(rf_b), 3);
    chk("R1", "if_a", int'(if_a), 0);
    chk("R1", "err", int'(err), 0);
    chk("R1", "lds", int'(lds), 0);

    // R3 R4 IF reference
    send(ref_word(1000, 1, 0, 2'b00)); latch();
    chk("R4", "if_ref", int'(if_ref), 1000);
    chk("R4", "if_cp", int'(if_cp), 1);
    chk("R3", "rf_ref untouched", int'(rf_ref), 3);

    // R11 RF reference at top of range, sets pin select
    send(ref_word(16383, 0, 1, 2'b01)); latch();
    chk("R3", "rf_ref", int'(rf_ref), 16383);
    chk("R11", "lds", int'(lds), 1);
    chk("R3", "if_ref kept", int'(if_ref), 1000);

    // R10 pin mux
    @(posedge clk); #1 pd_mon = 1'b1; lock_det = 1'b0;
    #0.5 chk("R10", "pin shows monitor", int'(ld_pin), 1);
    #0.5 pd_mon = 1'b0; lock_det = 1'b1;
    #0.5 chk("R10", "pin shows monitor low", int'(ld_pin), 0);

    // R5 programmable words
    send(prog_word(127, 2047, 1, 2'b10)); latch();
    chk("R5", "if_a", int'(if_a), 127);
    chk("R5", "if_b", int'(if_b), 2047);
    chk("R5", "if_ps", int'(if_ps), 1);
    send(prog_word(0, 3, 0, 2'b11)); latch();
    chk("R5", "rf_b min", int'(rf_b), 3);
    chk("R3", "if_b kept", int'(if_b), 2047);

    // R6 rejected reference word
    send(ref_word(2, 0, 0, 2'b00)); latch();
    chk("R6", "if_ref kept", int'(if_ref), 1000);
    chk("R6", "lds kept", int'(lds), 1);
    chk("R6", "err", int'(err), 1);

    // R7 rejected programmable word, err stays
    send(prog_word(9, 2, 1, 2'b11)); latch();
    chk("R7", "rf_b kept", int'(rf_b), 3);
    chk("R7", "rf_a kept", int'(rf_a), 0);
    chk("R7", "err", int'(err), 1);

    // R8 clear on accept
    send(prog_word(5, 100, 0, 2'b11)); latch();
    chk("R8", "err cleared", int'(err), 0);
    chk("R8", "rf_b", int'(rf_b), 100);

    // R2 extra leading bit falls off
    shift_bit(1'b1);
    send(ref_word(777, 0, 0, 2'b01)); latch();
    chk("R2", "rf_ref", int'(rf_ref), 777);
    chk("R11", "lds from RF word", int'(lds), 0);
    @(posedge clk); #1 lock_det = 1'b0;
    #0.5 chk("R10", "pin shows lock", int'(ld_pin), 0);

    // R9 same-cycle serial clock and latch enable, then pulses while high
    send(ref_word(500, 0, 0, 2'b00));
    @(posedge clk); #1 sclk = 1'b0; sdata = 1'b1;
    @(posedge clk); #1 sclk = 1'b1; le = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1 sclk = 1'b0;
      @(posedge clk); #1 sclk = 1'b1;
    end
    @(posedge clk); #1 le = 1'b0; sclk = 1'b0;
    @(negedge clk);
    chk("R9", "if_ref after collision", int'(if_ref), 500);
    chk("R9", "err", int'(err), 0);
    latch();
    chk("R9", "reload unchanged word", int'(if_ref), 500);
    send(ref_word(4321, 1, 1, 2'b00)); latch();
    chk("R9", "next word intact", int'(if_ref), 4321);
    chk("R4", "if_cp", int'(if_cp), 1);

    repeat (4) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule